// File: doc/BRIEF.md
# SPI Word Master with Transmit and Receive FIFOs

This block is a register-programmed SPI master that moves whole 32-bit words. Software writes words into a transmit queue through the data register. The block takes each queued word, shifts it out on MOSI most significant bit first over 32 SCK cycles, and captures MISO into a 32-bit word. It pushes that word into a receive queue, which software drains by reading the same data register. Clock polarity, clock phase and a sixteen-step clock divider are programmable. An optional byte reversal applies to every word on both paths. Chip select is driven elsewhere and is not part of this block.

The register window has four words, chosen by `reg_addr`: 0 is control, 1 is status, 2 is data and 3 is extension. Reads are combinational. A read strobe at the data address pops the receive queue. A status field reports the transfer engine's state and the queue flags. Two sticky flags record a completed word and a dropped write. An interrupt output signals that the transmit queue has been drained.

Top module: `spi_word_master`

## Requirements
- R1: After reset, control and extension read 0, status reads 0x05 (write queue empty in bit 2, read queue empty in bit 0, state 00), SCK is low and irq is low.
- R2: Each accepted data-register write (address 2) queues one word. The word is sent on MOSI most significant bit first over 32 SCK cycles, and the 32 bits sampled from MISO form one word in the receive queue. A read strobe at address 2 returns the oldest received word and removes it.
- R3: Control bit 3 sets the clock polarity, and SCK rests at that level between words. Control bit 2 sets the clock phase. With phase 0, MISO and MOSI are sampled on the first SCK edge of each bit. With phase 1, they are sampled on the second edge.
- R4: The divider select is {ext[1:0], ctrl[1:0]} (values 0 to 15), and the SCK period is 2^(select+1) clock cycles.
- R5: Status bit 3 is write-queue full, bit 2 is write-queue empty, bit 1 is read-queue full and bit 0 is read-queue empty. Each queue holds 8 words.
- R6: A data write while the write queue is full is dropped and sets status bit 6. Writing 1 to status bit 7 or bit 6 clears that flag.
- R7: Status bits 5:4 give the engine state: 00 idle, 01 load, 10 shifting, 11 done. Status bit 7 sets when a word reaches done.
- R8: When extension bit 5 is set, the byte order of each word is reversed before it is sent, and again before the received word is queued.
- R9: Extension bit 4 is stored and reads back, but it has no effect on the transfer.
- R10: When control bit 7 is set, irq goes high once the engine takes the last word from the write queue. irq goes low when a new data write is accepted.
- R11: A word is started only while control bit 6 (enable) and control bit 4 (master) are both 1. Otherwise queued words stay queued and SCK does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 2) |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 extension |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Write-queue-drained interrupt |

## Verification
The bench drives all four clock modes against a slave model that samples and launches on opposite edges. A phase error therefore shows up as a shifted word in one direction or the other. It fills the write queue past its depth: a block that accepted the ninth word, or did not raise the collision flag, would return a ninth word or a wrong status. It checks that the byte reversal appears on the wire and is undone on receive. It also checks that the high-speed bit changes nothing. It measures SCK periods at two divider settings, which exposes a select built from the wrong bits. It holds queued words with enable or master cleared, so a block that started anyway would toggle SCK.

// File: rtl/spi_word_master.sv
module spi_word_master #(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  localparam int PTR_W  = $clog2(FIFO_DEPTH);
  localparam int CNT_W  = PTR_W + 1;
  localparam int EDGE_W = $clog2(2 * WORD_W);
  localparam int NBYTES = WORD_W / 8;
  localparam int DIV_W  = 15;
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * WORD_W - 1);
  localparam logic [1:0] ST_IDLE = 2'b00, ST_LOAD = 2'b01, ST_SHIFT = 2'b10, ST_DONE = 2'b11;

  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < NBYTES; i++) r[i*8 +: 8] = w[(NBYTES-1-i)*8 +: 8];
    return r;
  endfunction

  logic [7:0] ctrl_r, ext_r;
  logic [1:0] state;
  logic       spif, wcol, drained, sck_r;
  logic [DIV_W-1:0]  div_cnt;
  logic [EDGE_W-1:0] edge_idx;
  logic [WORD_W-1:0] tx_sr, rx_sr;

  logic [WORD_W-1:0] txq [FIFO_DEPTH];
  logic [WORD_W-1:0] rxq [FIFO_DEPTH];
  logic [PTR_W-1:0]  tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;

  wire ie    = ctrl_r[7];
  wire spe   = ctrl_r[6];
  wire mstr  = ctrl_r[4];
  wire cpol  = ctrl_r[3];
  wire cpha  = ctrl_r[2];
  wire bswap = ext_r[5];
  wire [3:0] div_sel = {ext_r[1:0], ctrl_r[1:0]};

  wire tx_full  = tx_cnt == CNT_W'(FIFO_DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == CNT_W'(FIFO_DEPTH);
  wire rx_empty = rx_cnt == '0;

  wire wr_data = reg_wr && reg_addr == 2'd2;
  wire wr_stat = reg_wr && reg_addr == 2'd1;
  wire tx_push = wr_data && !tx_full;
  wire tx_pop  = state == ST_LOAD;
  wire rx_push = state == ST_DONE && !rx_full;
  wire rx_pop  = reg_rd && reg_addr == 2'd2 && !rx_empty;

  wire [DIV_W:0]   half_full = (DIV_W+1)'(1) << div_sel;
  wire [DIV_W-1:0] half_m1   = DIV_W'(half_full - 1'b1);
  wire tick        = div_cnt == half_m1;
  wire sample_edge = edge_idx[0] == cpha;
  wire shift_edge  = !sample_edge && edge_idx != '0;

  assign sck  = sck_r ^ cpol;
  assign mosi = tx_sr[WORD_W-1];
  assign irq  = ie && drained;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {{(WORD_W-8){1'b0}}, ctrl_r};
      2'd1:    reg_rdata = {{(WORD_W-8){1'b0}}, spif, wcol, state, tx_full, tx_empty, rx_full, rx_empty};
      2'd2:    reg_rdata = rxq[rx_rp];
      default: reg_rdata = {{(WORD_W-8){1'b0}}, ext_r};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      ext_r  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == 2'd0) ctrl_r <= reg_wdata[7:0];
      if (reg_addr == 2'd3) ext_r  <= reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txq[tx_wp] <= reg_wdata;
    if (rx_push) rxq[rx_wp] <= bswap ? swap_bytes(rx_sr) : rx_sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CNT_W'(tx_push) - CNT_W'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CNT_W'(rx_push) - CNT_W'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spif    <= 1'b0;
      wcol    <= 1'b0;
      drained <= 1'b0;
    end else begin
      if (wr_stat && reg_wdata[7]) spif <= 1'b0;
      if (wr_stat && reg_wdata[6]) wcol <= 1'b0;
      if (state == ST_DONE)        spif <= 1'b1;
      if (wr_data && tx_full)      wcol <= 1'b1;
      if (tx_push)                              drained <= 1'b0;
      else if (tx_pop && tx_cnt == CNT_W'(1))   drained <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sck_r    <= 1'b0;
      div_cnt  <= '0;
      edge_idx <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (spe && mstr && !tx_empty) state <= ST_LOAD;
        ST_LOAD: begin
          tx_sr    <= bswap ? swap_bytes(txq[tx_rp]) : txq[tx_rp];
          sck_r    <= 1'b0;
          div_cnt  <= '0;
          edge_idx <= '0;
          state    <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            div_cnt  <= '0;
            sck_r    <= ~sck_r;
            edge_idx <= edge_idx + 1'b1;
            if (sample_edge) rx_sr <= {rx_sr[WORD_W-2:0], miso};
            if (shift_edge)  tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
            if (edge_idx == LAST_EDGE) state <= ST_DONE;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state,
  input logic       sck,
  input logic       cpol,
  input logic       spe,
  input logic       mstr,
  input logic       spif,
  input logic       wcol,
  input logic       wr_data,
  input logic       tx_full,
  input logic       drained
);
  // R11
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b00 && !(spe && mstr)) |=> state == 2'b00);
  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b00) |-> sck == cpol);
  // R6
  collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full) |=> wcol);
  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b11) |=> spif);
  // R7
  load_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b01) |=> state == 2'b10);
  // R10
  drain_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drained) |-> $past(state) == 2'b01);
endmodule

bind spi_word_master spi_word_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .sck(sck), .cpol(cpol),
  .spe(spe), .mstr(mstr), .spif(spif), .wcol(wcol), .wr_data(wr_data),
  .tx_full(tx_full), .drained(drained)
);

// File: tb/sim_spi_word_master.sv
module sim_spi_word_master;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  wire  [31:0] reg_rdata;
  wire sck, mosi, irq;
  logic miso_s = 0, lb = 0;
  wire miso = lb ? mosi : miso_s;
  int checks = 0, fails = 0;
  longint cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_word_master u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq));

  logic cpol_m = 0, cpha_m = 0;
  logic [31:0] s_out = 0, s_in = 0;
  int lead_cnt = 0;
  int sck_toggles = 0;

  always @(sck) begin
    sck_toggles++;
    if (sck !== cpol_m) begin
      if (!cpha_m) s_in = {s_in[30:0], mosi};
      else begin
        if (lead_cnt > 0) s_out = {s_out[30:0], 1'b0};
        miso_s = s_out[31];
        lead_cnt++;
      end
    end else begin
      if (!cpha_m) begin s_out = {s_out[30:0], 1'b0}; miso_s = s_out[31]; end
      else s_in = {s_in[30:0], mosi};
    end
  end

  function automatic logic [31:0] bs(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic slave_load(input logic [31:0] w);
    s_out = w; lead_cnt = 0; s_in = 0;
    miso_s = cpha_m ? 1'b0 : w[31];
  endtask

  task automatic wait_done();
    logic [31:0] st;
    int n = 0;
    do begin rd(1, st); n++; end while (!st[7] && n < 20000);
    wr(1, 32'h80);
  endtask

  task automatic test_reset();
    logic [31:0] d;
    rd(1, d); chk("R1 status", d, 32'h05);
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(3, d); chk("R1 ext", d, 0);
    chk("R1 sck", {31'b0, sck}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic xfer(input string req, input bit cp, input bit ch, input bit sw,
                      input bit hs, input logic [31:0] tx, input logic [31:0] sv);
    logic [31:0] d;
    wr(3, {26'b0, sw, hs, 4'b0});
    wr(0, {24'b0, 1'b0, 1'b1, 1'b0, 1'b1, cp, ch, 2'b00});
    cpol_m = cp; cpha_m = ch;
    slave_load(sv);
    wr(2, tx);
    repeat (5) @(negedge clk);
    rd(1, d); chk({req, " R7 shifting"}, {30'b0, d[5:4]}, 32'h2);
    wait_done();
    chk({req, " R2 mosi word"}, s_in, sw ? bs(tx) : tx);
    chk({req, " R3 idle level"}, {31'b0, sck}, {31'b0, cp});
    rd(2, d); chk({req, " R2 rx word"}, d, sw ? bs(sv) : sv);
    rd(1, d); chk({req, " R5 empties"}, d, 32'h05);
  endtask

  task automatic test_modes();
    xfer("R3 mode0", 0, 0, 0, 0, 32'hA5C3_1E0F, 32'h1234_5678);
    xfer("R3 mode1", 0, 1, 0, 0, 32'h8000_0001, 32'hF0E1_D2C3);
    xfer("R3 mode2", 1, 0, 0, 0, 32'h0F0F_3C3C, 32'h8421_8421);
    xfer("R3 mode3", 1, 1, 0, 0, 32'hDEAD_BEEF, 32'h0000_0001);
  endtask

  task automatic test_swap();
    xfer("R8 swap m0", 0, 0, 1, 0, 32'h1122_3344, 32'hAABB_CCDD);
    xfer("R8 swap m3", 1, 1, 1, 0, 32'h0102_0304, 32'h5566_7788);
  endtask

  task automatic test_hs();
    logic [31:0] d;
    xfer("R9 hs", 0, 0, 0, 1, 32'hA5C3_1E0F, 32'h1234_5678);
    rd(3, d); chk("R9 ext readback", d, 32'h10);
  endtask

  task automatic period(input logic [1:0] es, input logic [1:0] cs, input int exp);
    longint t1, t2;
    wr(3, {30'b0, es});
    wr(0, {24'b0, 8'b0101_0000} | {30'b0, cs});
    cpol_m = 0; cpha_m = 0; slave_load(0);
    wr(2, 32'h5555_5555);
    @(posedge sck); t1 = cyc;
    @(posedge sck); t2 = cyc;
    chk("R4 sck period", 32'(t2 - t1), 32'(exp));
    wait_done();
    begin logic [31:0] d; rd(2, d); end
  endtask

  task automatic test_fifo();
    logic [31:0] d;
    wr(3, 0);
    wr(0, 32'h10);
    lb = 1;
    for (int i = 0; i < 8; i++) wr(2, 32'h1111_0000 + i * 32'h0101);
    rd(1, d); chk("R5 full", d, 32'h09);
    wr(2, 32'hBAD0_BAD0);
    rd(1, d); chk("R6 collision", d, 32'h49);
    wr(1, 32'h40);
    rd(1, d); chk("R6 w1c", d, 32'h09);
    wr(0, 32'h50);
    repeat (800) @(negedge clk);
    rd(1, d); chk("R5 read full", d, 32'h86);
    for (int i = 0; i < 8; i++) begin
      rd(2, d); chk("R2 fifo order", d, 32'h1111_0000 + i * 32'h0101);
    end
    rd(1, d); chk("R5 read empty", d, 32'h85);
    wr(1, 32'h80);
    rd(1, d); chk("R7 spif w1c", d, 32'h05);
    lb = 0;
  endtask

  task automatic test_hold();
    logic [31:0] d;
    int t0;
    wr(0, 32'h40);
    wr(2, 32'hCAFE_F00D);
    t0 = sck_toggles;
    repeat (100) @(negedge clk);
    rd(1, d); chk("R11 no master", d, 32'h01);
    wr(0, 32'h10);
    repeat (100) @(negedge clk);
    rd(1, d); chk("R11 no enable", d, 32'h01);
    chk("R11 sck still", 32'(sck_toggles - t0), 0);
    lb = 1;
    wr(0, 32'h50);
    wait_done();
    rd(2, d); chk("R11 released", d, 32'hCAFE_F00D);
    lb = 0;
  endtask

  task automatic test_irq();
    logic [31:0] d;
    lb = 1;
    wr(0, 32'hD0);
    wr(2, 32'h0000_00FF);
    repeat (5) @(negedge clk);
    chk("R10 irq raised", {31'b0, irq}, 1);
    wr(2, 32'h0000_FF00);
    chk("R10 irq cleared", {31'b0, irq}, 0);
    wait_done();
    wait_done();
    repeat (3) @(negedge clk);
    chk("R10 irq again", {31'b0, irq}, 1);
    rd(2, d); chk("R10 word1", d, 32'h0000_00FF);
    rd(2, d); chk("R10 word2", d, 32'h0000_FF00);
    wr(0, 32'h50);
    chk("R10 irq masked", {31'b0, irq}, 0);
    lb = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_modes();
    test_swap();
    test_hs();
    period(2'b00, 2'b11, 16);
    period(2'b01, 2'b01, 64);
    test_fifo();
    test_hold();
    test_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule